// File: doc/BRIEF.md
# Display Command Serial Transmitter

This block is a write-only serial master for a display controller's command port. A host writes one byte at a time together with a tag that marks it as a command or as a parameter. The block sends each byte on a single data pin using clock polarity 0 and phase 0, most significant bit first. It drives a chip-select line and a data/command line that tells the display how to interpret the byte.

Transmit-empty (`txe`) and busy (`bsy`) flags let the host sequence a transfer. After the last byte is written, `txe` rises first and `bsy` falls later. Only once `bsy` is low may the host drop the enable or let the chip select rise.

A one-byte holding register feeds an 8-bit shift register, so a command and its parameters can follow each other inside one chip-select window. The serial clock is the system clock divided by 2^(n+1), where n is a 3-bit selector. The data pin is half-duplex: its output enable follows the peripheral enable and a separate direction control.

Top module: `lcd_spi_tx`

## Requirements
- R1: Each byte appears on `sda_o` most significant bit first, one bit per rising `sclk` edge, eight rising edges per byte, and `sclk` rests low between bytes.
- R2: `sclk` changes level only while `cs_n` is low, and `cs_n` is already low before the first rising edge of a byte.
- R3: `dcx` carries the byte's tag (0 = command, 1 = parameter). The tag is taken when the byte enters the shift register and holds through all eight clocks of that byte.
- R4: `sda_oe` is high only when both `en` and `out_en` are high. While `out_en` is low no `sclk` edge is produced and a written byte waits, with `bsy` high, until `out_en` returns to 1.
- R5: While `en` is low, `cs_n` is high, `sclk` is low, `sda_oe` is low, `txe` is 1, `bsy` is 0, and writes are ignored.
- R6: `txe` is 1 exactly when the holding register is empty. A write presented while `txe` is 0 is discarded and never transmitted.
- R7: `bsy` rises with the accepted write and falls at the clock edge that ends the last bit, 16·2^n + 1 system cycles after the write edge. `txe` is back at 1 from the cycle after the write, while `bsy` is still high.
- R8: `cs_n` stays low without a gap across back-to-back bytes. Once `bsy` is 0, `cs_n` is high unless `frame_hold` is 1.
- R9: The `sclk` period is 2^(n+1) system clock cycles, where n is `div_sel`.
- R10: After reset, `cs_n` is 1, `sclk` is 0, `txe` is 1, `bsy` is 0 and `sda_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Peripheral enable |
| out_en | input | 1 | Data pin direction: 1 = transmit |
| div_sel | input | DIV_W (3) | Clock divide selector n |
| frame_hold | input | 1 | Keeps chip select low while idle |
| wr_valid | input | 1 | Write strobe for one byte |
| wr_data | input | 8 | Byte to send |
| wr_param | input | 1 | Tag: 0 = command, 1 = parameter |
| txe | output | 1 | Holding register empty |
| bsy | output | 1 | Transfer in progress or byte pending |
| cs_n | output | 1 | Chip select, active low |
| dcx | output | 1 | Data/command select |
| sclk | output | 1 | Serial clock |
| sda_o | output | 1 | Serial data out |
| sda_oe | output | 1 | Serial data output enable |

## Verification
The hardest case to reach from the ports is a write that arrives in the single cycle in which the holding register is full but has not yet been moved into the shifter. The bench reaches it by holding the write strobe high for two consecutive edges and expects only the first byte to come out. Back-to-back framing needs the next byte written inside the window between `txe` rising and the last bit ending. Random gaps in the stimulus, together with an immediate write whenever `txe` is seen high, produce both continuous frames and frames with idle gaps, while a monitor on `sclk` rebuilds every byte and its tag.

// File: rtl/lcd_spi_pkg.sv
// Shared types for the display command transmitter.
// Assumes an 8-bit byte; the tag bit marks parameter (1) or command (0).
package lcd_spi_pkg;
    localparam int BYTE_W = 8;

    typedef struct packed {
        logic                is_param;
        logic [BYTE_W-1:0]   bits;
    } tx_word_t;
endpackage

// File: rtl/spi_sclk_div.sv
// Half-period tick generator for the serial clock.
// Emits a one-cycle tick every 2^div_sel system cycles while run is high.
// Assumes div_sel is stable while run is high; the counter restarts from zero when run drops.
module spi_sclk_div #(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_sel,
    output logic             tick
);
    localparam int CNT_W = (2 ** DIV_W) - 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    // Terminal count of one half period
    assign half_m1 = ({{(CNT_W-1){1'b0}}, 1'b1} << div_sel) - 1'b1;
    assign tick    = run && (cnt >= half_m1);

    // Count system cycles within a half period
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tx_hold_buf.sv
// One-entry holding register in front of the shifter.
// Accepts a write only when empty and enabled; cleared whenever en is low.
module tx_hold_buf
    import lcd_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     wr_valid,
    input  tx_word_t wr_word,
    input  logic     take,
    output logic     full,
    output tx_word_t word
);
    // Fill on accepted write, empty on transfer to the shifter
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            full <= 1'b0;
            word <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full <= 1'b1;
            word <= wr_word;
        end
    end
endmodule

// File: rtl/tx_shift_eng.sv
// Mode-0 shift engine: loads a byte and its tag, then drives sclk and data MSB first.
// Data changes on the falling edge (or at load) and sclk rises at each odd tick.
// Assumes tick comes from a divider that runs only while run is high.
module tx_shift_eng
    import lcd_spi_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     out_en,
    input  logic     tick,
    input  logic     hold_full,
    input  tx_word_t hold_word,
    output logic     take,
    output logic     run,
    output logic     active,
    output logic     sclk,
    output logic     sda,
    output logic     dc
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BC_W-1:0]   bit_cnt;
    logic              last_fall;

    assign run       = active && en && out_en;
    assign last_fall = tick && sclk && (bit_cnt == LAST_BIT);
    assign take      = en && out_en && hold_full && (!active || last_fall);
    assign sda       = active ? shreg[BYTE_W-1] : 1'b0;

    // Load, toggle the clock and shift on each half-period tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            bit_cnt <= '0;
            shreg   <= '0;
            dc      <= 1'b1;
        end else if (!en) begin
            active  <= 1'b0;
            sclk    <= 1'b0;
            bit_cnt <= '0;
        end else if (take) begin
            active  <= 1'b1;
            sclk    <= 1'b0;
            bit_cnt <= '0;
            shreg   <= hold_word.bits;
            dc      <= hold_word.is_param;
        end else if (tick) begin
            if (!sclk) begin
                sclk <= 1'b1;
            end else begin
                sclk  <= 1'b0;
                shreg <= {shreg[BYTE_W-2:0], 1'b0};
                if (bit_cnt == LAST_BIT) active <= 1'b0;
                else                     bit_cnt <= bit_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/lcd_spi_tx.sv
// Write-only serial master for a display command port.
// Holding register + shifter, status flags txe/bsy, and chip-select framing.
// Assumes the host drops en only when bsy is 0 and changes div_sel only while idle.
module lcd_spi_tx
    import lcd_spi_pkg::*;
#(
    parameter int DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             out_en,
    input  logic [DIV_W-1:0] div_sel,
    input  logic             frame_hold,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_param,
    output logic             txe,
    output logic             bsy,
    output logic             cs_n,
    output logic             dcx,
    output logic             sclk,
    output logic             sda_o,
    output logic             sda_oe
);
    tx_word_t in_word, held;
    logic     hold_full, take, run, tick, active;

    assign in_word = '{is_param: wr_param, bits: wr_data};

    tx_hold_buf u_hold (
        .clk(clk), .rst_n(rst_n), .en(en), .wr_valid(wr_valid),
        .wr_word(in_word), .take(take), .full(hold_full), .word(held)
    );

    spi_sclk_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .tick(tick)
    );

    tx_shift_eng u_shift (
        .clk(clk), .rst_n(rst_n), .en(en), .out_en(out_en), .tick(tick),
        .hold_full(hold_full), .hold_word(held), .take(take), .run(run),
        .active(active), .sclk(sclk), .sda(sda_o), .dc(dcx)
    );

    // Status flags and chip-select framing
    assign txe    = !(en && hold_full);
    assign bsy    = en && (active || hold_full);
    assign cs_n   = !(en && (active || hold_full || frame_hold));
    assign sda_oe = en && out_en;
endmodule

// File: rtl/lcd_spi_tx_chk.sv
// Property checker for lcd_spi_tx, attached by bind; observes ports only.
module lcd_spi_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic out_en,
    input logic txe,
    input logic bsy,
    input logic cs_n,
    input logic dcx,
    input logic sclk,
    input logic sda_oe
);
    assert_sclk_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk != $past(sclk)) |-> !$past(cs_n));

    assert_dc_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(dcx));

    assert_oe_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> ($past(out_en) && $past(en)));

    assert_off_pins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (cs_n && !sda_oe && txe && !bsy));

    assert_off_clock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !sclk);

    assert_txe_bsy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !txe |-> bsy);

    assert_cs_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bsy |-> !cs_n);
endmodule

bind lcd_spi_tx lcd_spi_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .out_en(out_en), .txe(txe), .bsy(bsy),
    .cs_n(cs_n), .dcx(dcx), .sclk(sclk), .sda_oe(sda_oe)
);

// File: tb/sim_lcd_spi_tx.sv
module sim_lcd_spi_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0, out_en = 1'b0, frame_hold = 1'b0;
    logic [2:0] div_sel = 3'd0;
    logic       wr_valid = 1'b0, wr_param = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       txe, bsy, cs_n, dcx, sclk, sda_o, sda_oe;

    int tests = 0, fails = 0, rises = 0, rx_count = 0, cyc = 0;
    logic [8:0] exp_q[$];
    logic [7:0] rx_sh = 8'h00;
    logic       rx_dc = 1'b0;
    int         rx_bits = 0;

    lcd_spi_tx u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .out_en(out_en), .div_sel(div_sel),
        .frame_hold(frame_hold), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_param(wr_param), .txe(txe), .bsy(bsy), .cs_n(cs_n), .dcx(dcx),
        .sclk(sclk), .sda_o(sda_o), .sda_oe(sda_oe)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int byte_cycles(input logic [2:0] n);
        return 16 * (1 << n) + 1;
    endfunction

    // Byte monitor: rebuilds each byte from rising sclk edges
    always @(posedge sclk) begin
        rises++;
        check(!cs_n, "R2 cs_n low at rising sclk", cs_n, 0);
        check(sda_oe, "R4 oe high while clocking", sda_oe, 1);
        if (rx_bits == 0) rx_dc = dcx;
        else check(dcx == rx_dc, "R3 dcx stable in byte", dcx, rx_dc);
        rx_sh = {rx_sh[6:0], sda_o};
        rx_bits++;
        if (rx_bits == 8) begin
            logic [8:0] e;
            rx_bits = 0;
            rx_count++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected byte", {rx_dc, rx_sh}, 0);
            end else begin
                e = exp_q.pop_front();
                check({rx_dc, rx_sh} == e, "R1/R3 byte and tag", {rx_dc, rx_sh}, e);
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic put(input logic [7:0] d, input logic p, input bit expect_ok);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_param = p;
        @(negedge clk);
        wr_valid = 1'b0;
        if (expect_ok) exp_q.push_back({p, d});
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && bsy; i++) @(negedge clk);
    endtask

    task automatic wait_txe();
        for (int i = 0; i < 5000 && !txe; i++) @(negedge clk);
    endtask

    initial begin
        int n_cyc, r0, seed;
        bit gap_cs;
        seed = $urandom(32'h1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(cs_n && !sclk && txe && !bsy && !sda_oe, "R10 reset state",
              {cs_n, sclk, txe, bsy, sda_oe}, 5'b10100);

        // R5: writes ignored while disabled
        r0 = rises;
        put(8'h5A, 1'b1, 1'b0);
        repeat (40) @(negedge clk);
        check(txe && !bsy && cs_n && !sda_oe && rises == r0, "R5 disabled ignores write",
              {txe, bsy, cs_n, sda_oe}, 4'b1010);

        // Enable; single command byte at n=0
        en = 1'b1; out_en = 1'b1;
        @(negedge clk);
        check(sda_oe && cs_n, "R4 oe follows en&out_en", {sda_oe, cs_n}, 2'b11);
        put(8'hA5, 1'b0, 1'b1);
        n_cyc = 0;
        while (bsy && n_cyc < 5000) begin
            n_cyc++;
            if (n_cyc == 1) check(!txe && !cs_n, "R7 txe low after write", txe, 0);
            if (n_cyc == 2) check(txe && bsy, "R7 txe back before bsy falls", {txe, bsy}, 2'b11);
            @(negedge clk);
        end
        check(n_cyc == byte_cycles(3'd0), "R7/R9 byte time n=0", n_cyc, byte_cycles(3'd0));
        check(cs_n && !sclk, "R8 cs_n high after bsy, sclk idle low (R1)", {cs_n, sclk}, 2'b10);

        // R9 at n=2: parameter byte
        div_sel = 3'd2;
        put(8'h3C, 1'b1, 1'b1);
        n_cyc = 0;
        while (bsy && n_cyc < 5000) begin n_cyc++; @(negedge clk); end
        check(n_cyc == byte_cycles(3'd2), "R9 byte time n=2", n_cyc, byte_cycles(3'd2));
        div_sel = 3'd0;

        // R6: write presented while holding register still full is dropped
        r0 = rx_count;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'hC3; wr_param = 1'b0;
        exp_q.push_back({1'b0, 8'hC3});
        @(negedge clk);
        check(!txe, "R6 txe low with full hold", txe, 0);
        wr_data = 8'h7E; wr_param = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);
        check(rx_count == r0 + 1, "R6 dropped write not sent", rx_count - r0, 1);

        // R4: out_en low holds the byte
        out_en = 1'b0;
        r0 = rises;
        put(8'h81, 1'b1, 1'b1);
        repeat (50) @(negedge clk);
        check(rises == r0 && bsy && !sda_oe, "R4 no clock while out_en low",
              {rises - r0, bsy, sda_oe}, 3'b010);
        out_en = 1'b1;
        wait_idle();
        check(rises == r0 + 8, "R4 byte sent after out_en", rises - r0, 8);

        // R8: back-to-back bytes keep cs_n low
        gap_cs = 1'b0;
        put(8'h2A, 1'b0, 1'b1);
        wait_txe();
        put(8'h01, 1'b1, 1'b1);
        while (bsy) begin if (cs_n) gap_cs = 1'b1; @(negedge clk); end
        check(!gap_cs, "R8 no cs gap back-to-back", gap_cs, 0);
        frame_hold = 1'b1;
        @(negedge clk);
        check(!cs_n && !bsy, "R8 frame_hold keeps cs low", cs_n, 0);
        frame_hold = 1'b0;
        @(negedge clk);
        check(cs_n, "R8 cs high when idle", cs_n, 1);

        // Random traffic
        for (int k = 0; k < 60; k++) begin
            if (!bsy && ($urandom % 4 == 0)) div_sel = 3'($urandom % 3);
            frame_hold = 1'($urandom % 2);
            repeat ($urandom % 20) @(negedge clk);
            wait_txe();
            put(8'($urandom), 1'($urandom), 1'b1);
        end
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1 all random bytes received", exp_q.size(), 0);

        // R5: disable returns pins to idle
        frame_hold = 1'b1;
        en = 1'b0;
        @(negedge clk);
        check(cs_n && !sclk && !sda_oe && txe && !bsy, "R5 disabled idle pins",
              {cs_n, sclk, sda_oe, txe, bsy}, 5'b10010);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule